// File: doc/BRIEF.md
# Flash Write Guard

This block sits between the command decoder and the array sequencer of a serial flash device. It decides, one command at a time, whether a page program, a sector or block erase, a whole-array erase or a status-register write may go ahead. Every other case is refused. It holds the 8-bit status register, which contains the write-enable latch, the busy flag, the four region-protect bits, the quad-enable bit and the register-lock bit. The status byte is available at all times for read-back.

Commands arrive as single-cycle strobes, together with the target address, the level of the active-low write-protect pin and a top/bottom selection bit. One cycle after a strobe, the block answers with a grant pulse or an ignore pulse. An accepted write operation raises the busy flag. The busy flag stays high until the sequencer pulses the operation-complete input. Array reads are also checked: a read is refused while the device is busy.

Top module: `flash_wr_guard`

## Requirements
- R1: After reset, the status byte is 00h and no grant, ignore or read-grant pulse is present.
- R2: A write-enable strobe sets status bit 1 (WEL) and a write-disable strobe clears it. Both take effect on the next cycle and have no effect while status bit 0 (WIP) is 1.
- R3: With WEL = 0, a program, erase, whole-array erase or status-write strobe produces an ignore pulse and leaves the status byte unchanged.
- R4: A permitted program, erase, whole-array erase or status write produces a grant pulse and sets WIP, both one cycle after the strobe. An operation-complete pulse while WIP = 1 clears both WIP and WEL on the next cycle.
- R5: A status write carries the new values of bits 7..2 in the data byte: bit 7 is the lock (SRWD), bit 6 is QE, and bits 5..2 are the protect code BP3..BP0. When SRWD = 1 and the write-protect pin is low, the status write is ignored, bits 7..2 are kept and WEL is cleared. In every other case the status write is granted and bits 7..2 are loaded.
- R6: The block number is taken from the address bits above the 64 KB offset. Protect code 0 guards nothing. Code n from 1 to 8 guards 2^(n-1) blocks. Codes 9 to 15 guard all 256 blocks.
- R7: With the top/bottom bit at 0, the guarded blocks are counted down from the highest block. With the bit at 1, they are counted up from block 0.
- R8: A whole-array erase is granted only when the protect code is 0. Otherwise it is ignored and WEL is cleared.
- R9: A read strobe while WIP = 1 produces an ignore pulse and leaves WIP set. A read strobe while WIP = 0 produces a read-grant pulse.
- R10: A program or erase whose target block is guarded produces an ignore pulse, does not set WIP, and clears WEL.
- R11: Each strobe yields at most one of grant, ignore and read-grant, all in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_prog | input | 1 | Page program strobe |
| cmd_erase | input | 1 | Sector/block erase strobe |
| cmd_chip | input | 1 | Whole-array erase strobe |
| cmd_wrsr | input | 1 | Status-register write strobe |
| cmd_read | input | 1 | Array read strobe |
| op_done | input | 1 | Operation-complete pulse from the sequencer |
| tgt_addr | input | ADDR_W | Target byte address |
| wr_data | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| tb_sel | input | 1 | Guarded region anchor: 0 top, 1 bottom |
| op_grant | output | 1 | Write operation accepted |
| op_ignore | output | 1 | Command refused |
| rd_grant | output | 1 | Read accepted |
| status_q | output | 8 | Status byte {SRWD, QE, BP3..BP0, WEL, WIP} |

## Verification
The assertions take for granted that the command strobes are one-hot or idle in each cycle. They also assume that the operation-complete pulse arrives only while the busy flag is set. The properties about grants and about the lock therefore reason about one command per cycle. The stimulus drives exactly one strobe per step, and it returns every strobe low before the next step. It sends operation-complete only after a granted write and never while idle. The protect-code sweep rewrites the register only when the lock bit is clear.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

   localparam int SR_W = 8;
   localparam int BP_W = 4;

   typedef struct packed {
      logic            srwd;
      logic            qe;
      logic [BP_W-1:0] bp;
      logic            wel;
      logic            wip;
   } fwp_status_t;

endpackage

// File: rtl/fwp_region_decode.sv
module fwp_region_decode #(
   parameter int BLK_W = 8,
   parameter int BP_W  = 4
) (
   input  logic [BP_W-1:0]  bp,
   input  logic             tb_sel,
   input  logic [BLK_W-1:0] blk,
   output logic             hit
);
   localparam int IDX_W = $clog2(BLK_W);

   logic [BLK_W-1:0] top_m;
   logic [BLK_W-1:0] bot_m;
   logic [BP_W-1:0]  sel;

   // match for a region of 2^k blocks at either end of the array
   for (genvar k = 0; k < BLK_W; k++) begin : g_span
      assign top_m[k] = &blk[BLK_W-1:k];
      assign bot_m[k] = ~|blk[BLK_W-1:k];
   end

   always_comb begin
      sel = bp - BP_W'(1);
      if (bp == '0)
         hit = 1'b0;
      else if (int'(bp) > BLK_W)
         hit = 1'b1;
      else if (tb_sel)
         hit = bot_m[sel[IDX_W-1:0]];
      else
         hit = top_m[sel[IDX_W-1:0]];
   end
endmodule

// File: rtl/fwp_cmd_judge.sv
module fwp_cmd_judge
   import fwp_pkg::*;
(
   input  fwp_status_t st,
   input  logic        cmd_prog,
   input  logic        cmd_erase,
   input  logic        cmd_chip,
   input  logic        cmd_wrsr,
   input  logic        cmd_read,
   input  logic        wp_n,
   input  logic        prot_hit,
   output logic        grant_d,
   output logic        ignore_d,
   output logic        rd_d,
   output logic        load_sr,
   output logic        clr_wel
);
   logic wr_req;
   assign wr_req = cmd_prog | cmd_erase | cmd_chip | cmd_wrsr;

   always_comb begin
      grant_d  = 1'b0;
      ignore_d = 1'b0;
      rd_d     = 1'b0;
      load_sr  = 1'b0;
      clr_wel  = 1'b0;
      if (cmd_read) begin
         if (st.wip) ignore_d = 1'b1;
         else        rd_d     = 1'b1;
      end
      if (wr_req) begin
         if (st.wip || !st.wel) begin
            ignore_d = 1'b1;
         end else if ((cmd_prog || cmd_erase) && prot_hit) begin
            ignore_d = 1'b1;
            clr_wel  = 1'b1;
         end else if (cmd_chip && st.bp != '0) begin
            ignore_d = 1'b1;
            clr_wel  = 1'b1;
         end else if (cmd_wrsr && st.srwd && !wp_n) begin
            ignore_d = 1'b1;
            clr_wel  = 1'b1;
         end else begin
            grant_d = 1'b1;
            load_sr = cmd_wrsr;
         end
      end
   end
endmodule

// File: rtl/flash_wr_guard.sv
module flash_wr_guard
   import fwp_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int OFS_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wren,
   input  logic              cmd_wrdi,
   input  logic              cmd_prog,
   input  logic              cmd_erase,
   input  logic              cmd_chip,
   input  logic              cmd_wrsr,
   input  logic              cmd_read,
   input  logic              op_done,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic [SR_W-1:0]   wr_data,
   input  logic              wp_n,
   input  logic              tb_sel,
   output logic              op_grant,
   output logic              op_ignore,
   output logic              rd_grant,
   output logic [SR_W-1:0]   status_q
);
   localparam int BLK_W = ADDR_W - OFS_W;

   if (BLK_W < 2 || BLK_W > 14) begin : g_bad_geom
      $error("flash_wr_guard: block index width must be 2..14");
   end

   fwp_status_t st;
   logic prot_hit, grant_d, ignore_d, rd_d, load_sr, clr_wel;

   fwp_region_decode #(.BLK_W(BLK_W), .BP_W(BP_W)) u_region (
      .bp     (st.bp),
      .tb_sel (tb_sel),
      .blk    (tgt_addr[ADDR_W-1:OFS_W]),
      .hit    (prot_hit)
   );

   fwp_cmd_judge u_judge (
      .st        (st),
      .cmd_prog  (cmd_prog),
      .cmd_erase (cmd_erase),
      .cmd_chip  (cmd_chip),
      .cmd_wrsr  (cmd_wrsr),
      .cmd_read  (cmd_read),
      .wp_n      (wp_n),
      .prot_hit  (prot_hit),
      .grant_d   (grant_d),
      .ignore_d  (ignore_d),
      .rd_d      (rd_d),
      .load_sr   (load_sr),
      .clr_wel   (clr_wel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= '0;
         op_grant  <= 1'b0;
         op_ignore <= 1'b0;
         rd_grant  <= 1'b0;
      end else begin
         op_grant  <= grant_d;
         op_ignore <= ignore_d;
         rd_grant  <= rd_d;
         if (op_done && st.wip) begin
            st.wip <= 1'b0;
            st.wel <= 1'b0;
         end else begin
            if (grant_d) st.wip <= 1'b1;
            if (load_sr) {st.srwd, st.qe, st.bp} <= wr_data[SR_W-1:2];
            if (clr_wel) st.wel <= 1'b0;
            if (!st.wip && cmd_wren) st.wel <= 1'b1;
            if (!st.wip && cmd_wrdi) st.wel <= 1'b0;
         end
      end
   end

   assign status_q = st;
endmodule

// File: rtl/flash_wr_guard_chk.sv
module flash_wr_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_wren,
   input logic       cmd_prog,
   input logic       cmd_erase,
   input logic       cmd_chip,
   input logic       cmd_wrsr,
   input logic       cmd_read,
   input logic       op_done,
   input logic       wp_n,
   input logic       op_grant,
   input logic       op_ignore,
   input logic       rd_grant,
   input logic [7:0] status_q
);
   p_wren_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wren && !status_q[0]) |=> status_q[1]);

   p_no_wel_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_q[1] && (cmd_prog || cmd_erase || cmd_chip || cmd_wrsr)) |=> !op_grant);

   p_wip_from_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_q[0]) |-> op_grant);

   p_done_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && status_q[0]) |=> (!status_q[0] && !status_q[1]));

   p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wrsr && status_q[7] && !wp_n && !status_q[0]) |=> $stable(status_q[7:2]));

   p_chip_needs_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_chip && status_q[5:2] != 4'd0) |=> !op_grant);

   p_read_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_read && status_q[0] && !op_done) |=> (status_q[0] && !rd_grant));

   p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({op_grant, op_ignore, rd_grant}));
endmodule

bind flash_wr_guard flash_wr_guard_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_wren  (cmd_wren),
   .cmd_prog  (cmd_prog),
   .cmd_erase (cmd_erase),
   .cmd_chip  (cmd_chip),
   .cmd_wrsr  (cmd_wrsr),
   .cmd_read  (cmd_read),
   .op_done   (op_done),
   .wp_n      (wp_n),
   .op_grant  (op_grant),
   .op_ignore (op_ignore),
   .rd_grant  (rd_grant),
   .status_q  (status_q)
);

// File: tb/flash_wr_guard_tb_top.sv
module flash_wr_guard_tb_top;
   localparam int CLK_P = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_wren = 0, cmd_wrdi = 0, cmd_prog = 0, cmd_erase = 0;
   logic cmd_chip = 0, cmd_wrsr = 0, cmd_read = 0, op_done = 0;
   logic [23:0] tgt_addr = '0;
   logic [7:0]  wr_data = '0;
   logic wp_n = 1'b1, tb_sel = 1'b0;
   logic op_grant, op_ignore, rd_grant;
   logic [7:0] status_q;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_P/2) clk = ~clk;

   flash_wr_guard dut_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_prog(cmd_prog),
      .cmd_erase(cmd_erase), .cmd_chip(cmd_chip), .cmd_wrsr(cmd_wrsr),
      .cmd_read(cmd_read), .op_done(op_done), .tgt_addr(tgt_addr),
      .wr_data(wr_data), .wp_n(wp_n), .tb_sel(tb_sel),
      .op_grant(op_grant), .op_ignore(op_ignore), .rd_grant(rd_grant),
      .status_q(status_q)
   );

   // op codes: 0 idle, 1 wren, 2 wrdi, 3 prog, 4 erase, 5 chip, 6 wrsr, 7 read, 8 done
   // fields: op, blk, wp_n, tb_sel, data, grant, ignore, rd_grant, status
   localparam logic [32:0] VEC [34] = '{
      {4'd0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R1 idle
      {4'd3, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00}, // R3 prog without WEL
      {4'd6, 8'h00, 1'b1, 1'b0, 8'hFC, 1'b0, 1'b1, 1'b0, 8'h00}, // R3 wrsr without WEL
      {4'd1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h02}, // R2 wren
      {4'd2, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R2 wrdi
      {4'd1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h02}, // R2
      {4'd3, 8'h80, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h03}, // R4 prog granted
      {4'd7, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h03}, // R9 read while busy
      {4'd1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h03}, // R2 wren while busy
      {4'd8, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00}, // R4 done
      {4'd7, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00}, // R9 read idle
      {4'd1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h02},
      {4'd6, 8'h00, 1'b1, 1'b0, 8'h8C, 1'b1, 1'b0, 1'b0, 8'h8F}, // R5 lock=1 code 3
      {4'd8, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h8C},
      {4'd1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h8E},
      {4'd4, 8'hFB, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h8F}, // R6 block 251 free
      {4'd8, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h8C},
      {4'd1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h8E},
      {4'd3, 8'hFC, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h8C}, // R10 block 252 guarded
      {4'd1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h8E},
      {4'd3, 8'h03, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 8'h8C}, // R7 bottom block 3
      {4'd1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h8E},
      {4'd3, 8'h04, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h8F}, // R7 bottom block 4
      {4'd8, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h8C},
      {4'd1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h8E},
      {4'd5, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h8C}, // R8 chip with code 3
      {4'd1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h8E},
      {4'd6, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h8C}, // R5 locked, pin low
      {4'd1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h8E},
      {4'd6, 8'h00, 1'b1, 1'b0, 8'h40, 1'b1, 1'b0, 1'b0, 8'h43}, // R5 locked, pin high
      {4'd8, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h40},
      {4'd1, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h42},
      {4'd5, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h43}, // R8 chip with code 0
      {4'd8, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h40}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int op, input logic [7:0] blk, input logic wpn,
                       input logic tb, input logic [7:0] d);
      tgt_addr = {blk, 16'h0123};
      wp_n = wpn; tb_sel = tb; wr_data = d;
      cmd_wren  = (op == 1); cmd_wrdi = (op == 2); cmd_prog = (op == 3);
      cmd_erase = (op == 4); cmd_chip = (op == 5); cmd_wrsr = (op == 6);
      cmd_read  = (op == 7); op_done  = (op == 8);
      @(negedge clk);
      {cmd_wren, cmd_wrdi, cmd_prog, cmd_erase, cmd_chip, cmd_wrsr, cmd_read, op_done} = '0;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      check("R1 reset status", {21'b0, op_grant, op_ignore, rd_grant, status_q}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 34; i++) begin
         logic [32:0] v;
         v = VEC[i];
         step(int'(v[32:29]), v[28:21], v[20], v[19], v[18:11]);
         check($sformatf("R1..R11 vector %0d", i),
               {21'b0, op_grant, op_ignore, rd_grant, status_q}, {21'b0, v[10:0]});
      end

      // sweep of protect codes and both anchors
      for (int tb = 0; tb < 2; tb++) begin
         for (int code = 0; code < 16; code++) begin
            int cnt;
            cnt = (code == 0) ? 0 : (code >= 9) ? 256 : (1 << (code - 1));
            step(1, 8'h00, 1'b1, 1'b0, 8'h00);
            step(6, 8'h00, 1'b1, 1'b0, {2'b00, 4'(code), 2'b00});
            check("R5 status write granted", {31'b0, op_grant}, 32'h1);
            step(8, 8'h00, 1'b1, 1'b0, 8'h00);
            for (int j = 0; j < 6; j++) begin
               int b;
               bit p;
               case (j)
                  0: b = 0;   1: b = 1;   2: b = 127;
                  3: b = 128; 4: b = 254; default: b = 255;
               endcase
               p = (tb == 0) ? (b >= 256 - cnt) : (b < cnt);
               step(1, 8'h00, 1'b1, 1'b0, 8'h00);
               step(3, 8'(b), 1'b1, 1'(tb), 8'h00);
               check(tb == 0 ? "R6 top region" : "R7 bottom region",
                     {30'b0, op_grant, op_ignore}, {30'b0, !p, p});
               if (p)
                  check("R10 guarded keeps idle", {30'b0, status_q[1:0]}, 32'h0);
               else
                  step(8, 8'h00, 1'b1, 1'b0, 8'h00);
            end
         end
      end

      // reset in the middle of activity
      step(1, 8'h00, 1'b1, 1'b0, 8'h00);
      step(3, 8'h00, 1'b1, 1'b1, 8'h00);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-run", {24'b0, status_q}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule